// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block is the bit-timing layer of an I2C master. A controller hands it one command at a time: produce a START, produce a STOP, send a byte, receive a byte, or free a stuck bus. The engine turns the command into edges on the two open-drain wires and then reports back. It drives each wire only through an output enable. A high enable pulls the wire low. A low enable releases the wire, and the external pull-up then raises it. The engine watches the data wire through `sda_in`, returns the received byte and the acknowledge level it sampled, and pulses `done` for one cycle at the end of each command. Sequencing whole transactions is left to the controller.

Each bit period is four phases long. Each phase lasts `div_q + 1` clock cycles, and `div_q` is captured when a command is accepted. The state machine has five states:
- `ST_IDLE` accepts a strobe.
- `ST_START`, `ST_STOP`, `ST_BYTE` and `ST_RCLK` each step through phases 0 to 3 on every divider tick.

The transitions are:
- accept: `ST_IDLE` goes to the state the opcode selects.
- finish: after phase 3, `ST_START` and `ST_STOP` go back to `ST_IDLE`.
- next bit: `ST_BYTE` and `ST_RCLK` move to the next bit at the end of phase 3.
- byte end: `ST_BYTE` goes to `ST_IDLE` after bit DATA_W (the acknowledge bit).
- recovery end: `ST_RCLK` goes to `ST_STOP` after its ninth clock.

Inside a clocked bit, the four phases do the following:
- phase 0: the data wire takes its new level.
- phase 1: SCL is released.
- phase 2: `sda_in` is sampled at the end of this phase, which is the middle of the SCL-high window.
- phase 3: SCL is pulled low again at the end of this phase.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset the engine is idle: `scl_oe`=0, `sda_oe`=0, `busy`=0, `done`=0, `rdata`=0, `nack`=0. A wire is only ever pulled low or released, never driven high.
- R2: A command is accepted on a clock edge where `cmd_valid`=1 and the engine is idle. The opcodes are `cmd_op`: 1=START, 2=STOP, 3=WRITE, 4=READ, 5=RECOVER. Opcodes 0, 6 and 7 are ignored and leave `busy` low.
- R3: A strobe that arrives while `busy`=1 is ignored. The running command keeps its length and produces no other bus condition.
- R4: `done` rises a fixed number of clock edges after the accepting edge, with Q=`div_q`+1: 4·Q edges for START and STOP, 4·(DATA_W+1)·Q for WRITE and READ, and 4·(DATA_W+2)·Q for RECOVER.
- R5: START releases SDA and then SCL, pulls SDA low while SCL is high, then pulls SCL low. It ends with both wires held low, and it works both from idle and as a repeated START.
- R6: STOP pulls SCL low, then SDA low, releases SCL, and then releases SDA while SCL is high. It ends with both wires released.
- R7: WRITE shifts `cmd_wdata` out MSB first and changes SDA only while SCL is low. It releases SDA for clock DATA_W+1, and `nack` then holds the SDA level sampled on that clock (0 means ACK).
- R8: READ releases SDA for DATA_W clocks and stores the sampled bits MSB first in `rdata`. On clock DATA_W+1 it applies `cmd_ack_lvl`: 0 pulls SDA low (ACK) and 1 releases it (NACK). `nack` holds the level sampled on that clock.
- R9: RECOVER first pulls SCL low. It then gives exactly 9 SCL pulses with SDA released throughout, and always ends with a STOP.
- R10: `done` is high for exactly one cycle, and `busy` is already low in that cycle. `rdata` changes only at the end of a READ, and `nack` only at the end of a WRITE or READ. Both hold through START, STOP and RECOVER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_wdata | input | DATA_W | Byte to send for WRITE |
| cmd_ack_lvl | input | 1 | Acknowledge level to send after a READ (0 = ACK) |
| div_q | input | DIV_W | Phase length minus one, in clock cycles |
| sda_in | input | 1 | Sampled level of the data wire |
| scl_oe | output | 1 | 1 pulls the clock wire low |
| sda_oe | output | 1 | 1 pulls the data wire low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| rdata | output | DATA_W | Last byte received |
| nack | output | 1 | Last acknowledge level sampled |

## Verification
Each result is due a fixed number of edges after the accepting edge. `done` rises after 4, 36 or 40 phases (R4), and the received byte and the acknowledge flag become visible in that same cycle. The bench drives every input 1 ns after a rising edge and counts the edges from acceptance to `done`. It compares that count with the expected phase count times Q, using Q values of 1, 2 and 4. It samples every output in the same post-edge slot. Bus conditions and the bit on the wire at each SCL rise are taken from a wire-level monitor on the falling clock edge, so each check compares against a whole command's worth of wire activity and not against any particular cycle inside it.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    localparam logic [2:0] OP_START   = 3'd1;
    localparam logic [2:0] OP_STOP    = 3'd2;
    localparam logic [2:0] OP_WRITE   = 3'd3;
    localparam logic [2:0] OP_READ    = 3'd4;
    localparam logic [2:0] OP_RECOVER = 3'd5;

    localparam int RECOVER_PULSES = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_STOP,
        ST_BYTE,
        ST_RCLK
    } eng_state_e;

endpackage

// File: rtl/i2c_eng_tick.sv
module i2c_eng_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_q,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_l <= '0;
        end else if (restart) begin
            cnt   <= div_q;
            div_l <= div_q;
        end else if (run) begin
            if (cnt == '0) cnt <= div_l;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

endmodule

// File: rtl/i2c_eng_shift.sv
module i2c_eng_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              sin,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[DATA_W-2:0], sin};
    end

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_eng_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ack_lvl,
    input  logic [DIV_W-1:0]  div_q,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              nack
);

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] RCLK_END = CNT_W'(RECOVER_PULSES - 1);

    eng_state_e       state, state_n;
    logic [1:0]       phase, phase_n;
    logic [CNT_W-1:0] bitn, bit_n;

    logic              accept, tick, op_ok;
    logic              rd_mode, ack_l, ack_smp, bitval;
    logic              sh_shift;
    logic [DATA_W-1:0] sh_val, sh_q;
    logic              last_bit;

    assign op_ok    = (cmd_op >= OP_START) && (cmd_op <= OP_RECOVER);
    assign accept   = (state == ST_IDLE) && cmd_valid && op_ok;
    assign busy     = (state != ST_IDLE);
    assign last_bit = (bitn == ACK_BIT);
    assign sh_val   = (cmd_op == OP_WRITE) ? cmd_wdata : '1;
    assign sh_shift = tick && (state == ST_BYTE) && (phase == 2'd2) && !last_bit;

    i2c_eng_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .div_q   (div_q),
        .tick    (tick)
    );

    i2c_eng_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (sh_val),
        .shift    (sh_shift),
        .sin      (sda_in),
        .q        (sh_q)
    );

    // Level to leave on SDA for the current clocked bit (1 = released)
    always_comb begin
        if (state == ST_RCLK) bitval = 1'b1;
        else if (last_bit)    bitval = rd_mode ? ack_l : 1'b1;
        else                  bitval = rd_mode ? 1'b1 : sh_q[DATA_W-1];
    end

    // State register with its next-state logic
    always_comb begin
        state_n = state;
        phase_n = phase;
        bit_n   = bitn;
        if (accept) begin
            phase_n = 2'd0;
            bit_n   = '0;
            unique case (cmd_op)
                OP_START: state_n = ST_START;
                OP_STOP:  state_n = ST_STOP;
                OP_WRITE, OP_READ: state_n = ST_BYTE;
                OP_RECOVER: state_n = ST_RCLK;
                default:  state_n = ST_IDLE;
            endcase
        end else if (tick) begin
            phase_n = phase + 2'd1;
            if (phase == 2'd3) begin
                unique case (state)
                    ST_START, ST_STOP: state_n = ST_IDLE;
                    ST_BYTE: begin
                        if (last_bit) state_n = ST_IDLE;
                        else          bit_n   = bitn + CNT_W'(1);
                    end
                    ST_RCLK: begin
                        if (bitn == RCLK_END) begin
                            state_n = ST_STOP;
                            bit_n   = '0;
                        end else begin
                            bit_n = bitn + CNT_W'(1);
                        end
                    end
                    default: state_n = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= 2'd0;
            bitn  <= '0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            bitn  <= bit_n;
        end
    end

    // Output process: wire enables, results, done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
            nack    <= 1'b0;
            rd_mode <= 1'b0;
            ack_l   <= 1'b1;
            ack_smp <= 1'b1;
        end else begin
            done <= 1'b0;
            if (accept) begin
                rd_mode <= (cmd_op == OP_READ);
                ack_l   <= cmd_ack_lvl;
                if (cmd_op == OP_RECOVER) begin
                    scl_oe <= 1'b1;
                    sda_oe <= 1'b0;
                end
            end else if (tick) begin
                unique case (state)
                    ST_START: begin
                        unique case (phase)
                            2'd0:    sda_oe <= 1'b0;
                            2'd1:    scl_oe <= 1'b0;
                            2'd2:    sda_oe <= 1'b1;
                            default: begin
                                scl_oe <= 1'b1;
                                done   <= 1'b1;
                            end
                        endcase
                    end
                    ST_STOP: begin
                        unique case (phase)
                            2'd0:    scl_oe <= 1'b1;
                            2'd1:    sda_oe <= 1'b1;
                            2'd2:    scl_oe <= 1'b0;
                            default: begin
                                sda_oe <= 1'b0;
                                done   <= 1'b1;
                            end
                        endcase
                    end
                    ST_BYTE, ST_RCLK: begin
                        unique case (phase)
                            2'd0:    sda_oe <= ~bitval;
                            2'd1:    scl_oe <= 1'b0;
                            2'd2:    ack_smp <= sda_in;
                            default: begin
                                scl_oe <= 1'b1;
                                if (state == ST_BYTE && last_bit) begin
                                    done <= 1'b1;
                                    nack <= ack_smp;
                                    if (rd_mode) rdata <= sh_q;
                                end
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk
    import i2c_eng_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input eng_state_e        st,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic [DATA_W-1:0] rdata,
    input logic              nack
);

    // R2: the engine only leaves idle on a strobe
    assert_launch_by_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R5: inside START, SDA is pulled low only while SCL is released
    assert_start_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START && $rose(sda_oe)) |-> !scl_oe);

    // R6: the finishing SDA release of a STOP happens with SCL released
    assert_stop_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && done) |-> (!scl_oe && $past(!scl_oe)));

    // R7: within clocked bits, SDA moves only while SCL is held low
    assert_sda_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_BYTE || st == ST_RCLK) && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));

    // R9: SDA stays released during the recovery clocks
    assert_recover_sda_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RCLK) |-> !sda_oe);

    // R10: done is a single-cycle pulse and coincides with idle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: results change only together with done
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);

    assert_nack_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nack) |-> done);

endmodule

bind i2c_bit_engine i2c_bit_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (state),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .done      (done),
    .cmd_valid (cmd_valid),
    .rdata     (rdata),
    .nack      (nack)
);

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       cmd_ack_lvl = 1'b1;
    logic [15:0] div_q = 16'd3;
    logic       sda_in;
    logic       scl_oe, sda_oe, busy, done, nack;
    logic [7:0] rdata;

    always #4 clk = ~clk;

    i2c_bit_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_ack_lvl(cmd_ack_lvl), .div_q(div_q),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .done(done), .rdata(rdata), .nack(nack)
    );

    // Wired-AND bus model with a simple target
    logic       slave_low = 1'b0;
    logic [8:0] slave_pat = 9'h1FF;
    int         sl_idx = 0;
    int         n_start = 0, n_stop = 0, n_rise = 0;
    logic [8:0] obs = 9'h0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;

    assign sda_in = ~sda_oe & ~slave_low;

    always @(negedge clk) begin
        logic scl_l, sda_l;
        scl_l = ~scl_oe;
        sda_l = ~sda_oe & ~slave_low;
        if (prev_scl === 1'b1 && scl_l === 1'b1 && prev_sda === 1'b1 && sda_l === 1'b0) n_start++;
        if (prev_scl === 1'b1 && scl_l === 1'b1 && prev_sda === 1'b0 && sda_l === 1'b1) n_stop++;
        if (prev_scl === 1'b0 && scl_l === 1'b1) begin
            if (n_rise < 9) obs = {obs[7:0], sda_l};
            n_rise++;
        end
        if (prev_scl === 1'b1 && scl_l === 1'b0) begin
            if (sl_idx < 8) slave_low = ~slave_pat[7 - sl_idx];
            else            slave_low = 1'b0;
            sl_idx++;
        end
        prev_scl = scl_l;
        prev_sda = ~sda_oe & ~slave_low;
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one command, count edges to done, check pulse shape
    task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input logic ack,
                           input logic [8:0] pat, input bit do_poke, input logic [2:0] poke,
                           input int exp_cyc, input string req);
        int cyc;
        slave_pat = pat;
        sl_idx    = 0;
        slave_low = ~pat[8];
        n_start = 0; n_stop = 0; n_rise = 0; obs = 9'h0;
        cmd_op = op; cmd_wdata = wd; cmd_ack_lvl = ack; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cyc = 0;
        while (1) begin
            @(posedge clk); #1;
            cyc++;
            if (do_poke && cyc == 3) begin
                cmd_valid = 1'b1;
                cmd_op    = poke;
            end else begin
                cmd_valid = 1'b0;
            end
            if (done === 1'b1 || cyc > 5000) break;
        end
        check(req, "edges to done (R4)", cyc, exp_cyc);
        check("R10", "busy low with done", {31'd0, busy}, 32'd0);
        @(posedge clk); #1;
        check("R10", "done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1", "scl_oe", {31'd0, scl_oe}, 0);
        check("R1", "sda_oe", {31'd0, sda_oe}, 0);
        check("R1", "busy",   {31'd0, busy}, 0);
        check("R1", "done",   {31'd0, done}, 0);
        check("R1", "rdata",  {24'd0, rdata}, 0);
        check("R1", "nack",   {31'd0, nack}, 0);
    endtask

    task automatic t_start(input int q, input string tag);
        run_cmd(3'd1, 8'h00, 1'b1, 9'h1FF, 1'b0, 3'd0, 4 * q, "R4");
        check("R5", {tag, " start count"}, n_start, 1);
        check("R5", {tag, " stop count"}, n_stop, 0);
        check("R5", {tag, " lines held"}, {30'd0, scl_oe, sda_oe}, 32'd3);
    endtask

    task automatic t_stop(input int q);
        run_cmd(3'd2, 8'h00, 1'b1, 9'h1FF, 1'b0, 3'd0, 4 * q, "R4");
        check("R6", "stop count", n_stop, 1);
        check("R6", "start count", n_start, 0);
        check("R6", "lines released", {30'd0, scl_oe, sda_oe}, 0);
    endtask

    task automatic t_write(input logic [7:0] d, input logic slave_ack, input int q);
        logic [7:0] keep;
        keep = rdata;
        run_cmd(3'd3, d, 1'b1, {8'hFF, slave_ack}, 1'b0, 3'd0, 36 * q, "R4");
        check("R7", "bits on wire", {23'd0, obs}, {23'd0, d, slave_ack});
        check("R7", "scl pulses", n_rise, 9);
        check("R7", "nack flag", {31'd0, nack}, {31'd0, slave_ack});
        check("R10", "rdata kept by write", {24'd0, rdata}, {24'd0, keep});
    endtask

    task automatic t_read(input logic [7:0] d, input logic ack);
        run_cmd(3'd4, 8'h00, ack, {d, 1'b1}, 1'b0, 3'd0, 144, "R4");
        check("R8", "rdata", {24'd0, rdata}, {24'd0, d});
        check("R8", "bits on wire", {23'd0, obs}, {23'd0, d, ack});
        check("R8", "nack flag", {31'd0, nack}, {31'd0, ack});
    endtask

    task automatic t_busy_ignore;
        run_cmd(3'd1, 8'h00, 1'b1, 9'h1FF, 1'b1, 3'd2, 16, "R3");
        check("R3", "no stop from strobe while busy", n_stop, 0);
        check("R3", "repeated start seen (R5)", n_start, 1);
        repeat (3) begin
            @(posedge clk); #1;
            check("R3", "poke did not start a command", {31'd0, busy}, 0);
        end
    endtask

    task automatic t_recover;
        run_cmd(3'd5, 8'h00, 1'b1, 9'h1FF, 1'b0, 3'd0, 160, "R4");
        check("R9", "scl pulses incl. stop", n_rise, 10);
        check("R9", "sda released on 9 pulses", {23'd0, obs}, 32'h1FF);
        check("R9", "stop count", n_stop, 1);
        check("R9", "start count", n_start, 0);
        check("R9", "lines released", {30'd0, scl_oe, sda_oe}, 0);
        check("R10", "rdata kept", {24'd0, rdata}, 32'h5A);
        check("R10", "nack kept", {31'd0, nack}, 1);
    endtask

    task automatic t_bad_ops;
        for (int k = 0; k < 3; k++) begin
            cmd_op = (k == 0) ? 3'd0 : ((k == 1) ? 3'd6 : 3'd7);
            cmd_valid = 1'b1;
            @(posedge clk); #1;
            cmd_valid = 1'b0;
            repeat (2) @(posedge clk);
            #1;
            check("R2", "undefined opcode ignored", {29'd0, busy, scl_oe, sda_oe}, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        div_q = 16'd3;
        t_start(4, "R5 idle");
        t_write(8'hA5, 1'b0, 4);
        t_write(8'h3C, 1'b1, 4);
        t_busy_ignore();
        t_read(8'h96, 1'b0);
        t_read(8'h5A, 1'b1);
        t_stop(4);
        check("R10", "rdata kept by stop", {24'd0, rdata}, 32'h5A);
        t_recover();
        div_q = 16'd0;
        t_start(1, "R5 fast");
        t_write(8'h81, 1'b0, 1);
        t_stop(1);
        div_q = 16'd1;
        t_start(2, "R5 mid");
        t_stop(2);
        t_bad_ops();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule